// File: doc/BRIEF.md
# Register-Mapped Random Byte Peripheral

This peripheral passes random bytes from an external entropy supply to software. Software sees three byte-wide registers in a 4 KiB window. The first is a control/status register. It holds a run-enable bit, a hardware-owned "byte ready" flag, a 4-bit prescaler field that is only stored, and two spare bits that are also only stored. The second is a read-only data register that holds the latched byte. The third is a mode register. Bytes come in over a valid/ready handshake. The block takes one byte at a time, and only while it is running and holding nothing.

The generator runs only when the enable bit is set and the mode register holds exactly the run code. Software polls the ready flag and then reads the data register. That read returns the byte, clears the flag and zeroes the stored copy, so each byte is handed out at most once. A read with no byte present returns zero and changes nothing. Bus reads are registered: the result and an error pulse for an undefined offset both appear in the cycle after the request.

Top module: `rng_byte_port`

## Requirements
- R1: After reset the control/status register and the mode register read 0x00, a data read returns 0x00, and `ent_ready` is low.
- R2: Only byte offsets 0x000 (control/status), 0x004 (data) and 0x008 (mode) are decoded. A read at any other offset returns 0x00, a write there changes no register, and either access raises `bus_err` for one cycle.
- R3: A control/status write stores bit 0 (enable), bits 5:2 (prescaler) and bits 7:6 (spare). Bit 1 of the write is discarded. The readback is {bits 7:2, ready flag, enable}.
- R4: The mode register is fully readable and writable over all 8 bits.
- R5: The generator is active exactly when the enable bit is 1 and the mode register holds 0x02. `ent_ready` is high when the generator is active and no byte is held.
- R6: A byte is latched only on a clock edge where `ent_valid` and `ent_ready` are both high. Once latched, control/status bit 1 reads 1.
- R7: A data read while active with the flag set returns the held byte, clears the flag and zeroes the stored byte. A second data read then returns 0x00.
- R8: A data read while inactive, or while no byte is held, returns 0x00 and changes nothing.
- R9: While inactive the ready flag reads 0. After the generator is reactivated, a new entropy byte must arrive before the flag sets again.
- R10: Writes to the data register are ignored, and the held byte and the flag stay as they were.
- R11: When a data read that consumes a byte falls in the same cycle as an offered entropy byte, the read wins. The offered byte is not taken on that edge, and it can be taken no earlier than the next edge.
- R12: `bus_rdata` and `bus_err` reflect a request in the cycle after it. `bus_err` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data, updated on each read |
| bus_err | output | 1 | One-cycle pulse for an access to an undefined offset |
| ent_valid | input | 1 | Entropy byte offered |
| ent_data | input | 8 | Entropy byte |
| ent_ready | output | 1 | Block can latch an entropy byte on this edge |

## Verification
Two functions can fall in one cycle. A data-register read can empty the holding register while the entropy side is offering the next byte. The bench provokes this by raising a data read and `ent_valid` with a new byte in the same cycle while a byte is held. It then checks three things: the read returns the old byte, `ent_ready` is high again with the new byte not yet taken, and the new byte comes out only after one more cycle of `ent_valid`. A second collision is a mode or enable change that drops the active state while a byte is held. That case is judged by the ready flag reading 0 and by the byte being withheld after reactivation.

// File: rtl/rng_byte_pkg.sv
package rng_byte_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_DATA = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;

  localparam int CS_EN_BIT  = 0;
  localparam int CS_RDY_BIT = 1;
  localparam int CS_HI_LSB  = 2;

endpackage

// File: rtl/rng_addr_decode.sv
module rng_addr_decode
  import rng_byte_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int OFF_CTRL = 0,
  parameter int OFF_DATA = 4,
  parameter int OFF_MODE = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFF_MODE);

  always_comb begin
    sel = SEL_NONE;
    if (addr == A_CTRL)      sel = SEL_CTRL;
    else if (addr == A_DATA) sel = SEL_DATA;
    else if (addr == A_MODE) sel = SEL_MODE;
  end

endmodule

// File: rtl/rng_cfg_regs.sv
module rng_cfg_regs
  import rng_byte_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RUN_CODE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic              en,
  output logic [DATA_W-1:CS_HI_LSB] ctrl_hi,
  output logic [DATA_W-1:0] mode,
  output logic              active
);

  localparam logic [DATA_W-1:0] RUN_VAL = DATA_W'(RUN_CODE);

  logic                    en_q, en_d;
  logic [DATA_W-1:CS_HI_LSB] hi_q, hi_d;
  logic [DATA_W-1:0]       mode_q, mode_d;

  always_comb begin
    en_d   = en_q;
    hi_d   = hi_q;
    mode_d = mode_q;
    if (wr_ctrl) begin
      en_d = wdata[CS_EN_BIT];
      hi_d = wdata[DATA_W-1:CS_HI_LSB];
    end
    if (wr_mode) mode_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      hi_q   <= '0;
      mode_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q <= en_d;
        hi_q <= hi_d;
      end
      if (wr_mode) mode_q <= mode_d;
    end
  end

  assign en      = en_q;
  assign ctrl_hi = hi_q;
  assign mode    = mode_q;
  assign active  = en_q && (mode_q == RUN_VAL);

  AST_MODE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode_q == $past(wdata)));  // R4

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q));  // R2

endmodule

// File: rtl/rng_entropy_hold.sv
module rng_entropy_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              ent_valid,
  input  logic [DATA_W-1:0] ent_data,
  input  logic              take_req,
  output logic              ent_ready,
  output logic              flag_vis,
  output logic              take_hit,
  output logic [DATA_W-1:0] held
);

  logic              flag_q, flag_d;
  logic [DATA_W-1:0] held_q, held_d;
  logic              accept;

  assign ent_ready = active && !flag_q;
  assign accept    = ent_valid && ent_ready;
  assign take_hit  = take_req && active && flag_q;

  always_comb begin
    flag_d = flag_q;
    held_d = held_q;
    if (take_hit) begin
      flag_d = 1'b0;
      held_d = '0;
    end else if (accept) begin
      flag_d = 1'b1;
      held_d = ent_data;
    end
    if (!active) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      held_q <= '0;
    end else begin
      flag_q <= flag_d;
      if (take_hit || accept) held_q <= held_d;
    end
  end

  assign flag_vis = flag_q && active;
  assign held     = held_q;

  AST_ACCEPT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_ready) |=> (flag_q && held_q == $past(ent_data)));  // R6

  AST_TAKE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    take_hit |=> (!flag_q && held_q == '0));  // R7

  AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !flag_q);  // R9

  AST_TAKE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_hit && ent_valid) |=> !flag_q);  // R11

endmodule

// File: rtl/rng_byte_port.sv
module rng_byte_port
  import rng_byte_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int RUN_CODE = 2,
  parameter int OFF_CTRL = 0,
  parameter int OFF_DATA = 4,
  parameter int OFF_MODE = 8,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              ent_valid,
  input  logic [DATA_W-1:0] ent_data,
  output logic              ent_ready
);

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_s_n = rst_pipe[SYNC_N-1];

  reg_sel_e sel;

  rng_addr_decode #(
    .ADDR_W(ADDR_W), .OFF_CTRL(OFF_CTRL), .OFF_DATA(OFF_DATA), .OFF_MODE(OFF_MODE)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  logic                      en, active;
  logic [DATA_W-1:CS_HI_LSB] ctrl_hi;
  logic [DATA_W-1:0]         mode;
  logic                      wr_ctrl, wr_mode;

  assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
  assign wr_mode = bus_wr && (sel == SEL_MODE);

  rng_cfg_regs #(.DATA_W(DATA_W), .RUN_CODE(RUN_CODE)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_ctrl(wr_ctrl),
    .wr_mode(wr_mode),
    .wdata  (bus_wdata),
    .en     (en),
    .ctrl_hi(ctrl_hi),
    .mode   (mode),
    .active (active)
  );

  logic              flag_vis, take_hit;
  logic [DATA_W-1:0] held;

  rng_entropy_hold #(.DATA_W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .active   (active),
    .ent_valid(ent_valid),
    .ent_data (ent_data),
    .take_req (bus_rd && (sel == SEL_DATA)),
    .ent_ready(ent_ready),
    .flag_vis (flag_vis),
    .take_hit (take_hit),
    .held     (held)
  );

  logic [DATA_W-1:0] rdata_d, rdata_q;
  logic              err_d, err_q;

  always_comb begin
    rdata_d = '0;
    unique case (sel)
      SEL_CTRL: rdata_d = {ctrl_hi, flag_vis, en};
      SEL_DATA: rdata_d = take_hit ? held : '0;
      SEL_MODE: rdata_d = mode;
      default:  rdata_d = '0;
    endcase
    err_d = (bus_rd || bus_wr) && (sel == SEL_NONE);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rdata_d;
      err_q <= err_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_q |-> $past(bus_rd || bus_wr));  // R12

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && sel == SEL_NONE) |=> (rdata_q == '0));  // R2

  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && sel == SEL_DATA && !active) |=> (rdata_q == '0));  // R8

endmodule

// File: tb/test_rng_byte_port.sv
module test_rng_byte_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_err;
  logic        ent_valid = 1'b0;
  logic [7:0]  ent_data = '0;
  logic        ent_ready;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rng_byte_port i_rng_byte_port (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .ent_valid(ent_valid), .ent_data(ent_data), .ent_ready(ent_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  logic [7:0] rd_v;
  logic       rd_e;

  task automatic rd(input int a);
    @(negedge clk);
    bus_addr = 12'(a); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    rd_v = bus_rdata;
    rd_e = bus_err;
  endtask

  task automatic push(input int b);
    @(negedge clk);
    ent_valid = 1'b1; ent_data = 8'(b);
    @(negedge clk);
    ent_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 ready", int'(ent_ready), 0);
    rd(0);  chk("R1 ctrl", rd_v, 0);
    rd(8);  chk("R1 mode", rd_v, 0);
    rd(4);  chk("R1 data", rd_v, 0);
    chk("R12 no err on defined", int'(rd_e), 0);

    // R3 every control write value, generator inactive (mode 0)
    for (int v = 0; v < 256; v++) begin
      wr(0, v);
      rd(0);
      chk("R3 ctrl readback", rd_v, v & 8'hFD);
    end
    wr(0, 0);

    // R4 / R5 sweep mode code against enable
    for (int m = 0; m < 256; m++) begin
      for (int e = 0; e < 2; e++) begin
        wr(8, m);
        wr(0, e);
        @(negedge clk);
        chk("R5 ready vs active", int'(ent_ready), (e == 1 && m == 2) ? 1 : 0);
        rd(8);
        chk("R4 mode readback", rd_v, m);
      end
    end

    // R6 / R7 / R8 every byte value through the holder
    wr(8, 2); wr(0, 1);
    @(negedge clk);
    ent_data = 8'hEE;
    @(negedge clk);
    rd(0); chk("R6 no latch without valid", rd_v, 8'h01);
    rd(4); chk("R8 empty data read", rd_v, 0);
    for (int b = 0; b < 256; b++) begin
      chk("R5 ready before byte", int'(ent_ready), 1);
      push(b);
      chk("R6 ready drops when full", int'(ent_ready), 0);
      rd(0); chk("R6 flag set", rd_v, 8'h03);
      rd(4); chk("R7 byte returned", rd_v, b);
      rd(4); chk("R7 second read zero", rd_v, 0);
    end

    // R10 data register write ignored
    push(8'h5A);
    wr(4, 8'hFF);
    rd(0); chk("R10 flag kept", rd_v, 8'h03);
    rd(4); chk("R10 byte kept", rd_v, 8'h5A);

    // R8 / R9 leaving the run mode with a byte held
    push(8'h33);
    wr(8, 3);
    rd(0); chk("R9 flag forced low by mode", rd_v, 8'h01);
    rd(4); chk("R8 inactive data read", rd_v, 0);
    wr(8, 2);
    rd(0); chk("R9 flag stays low after reactivation", rd_v, 8'h01);
    rd(4); chk("R9 old byte withheld", rd_v, 0);
    push(8'h44);
    wr(0, 0);
    rd(0); chk("R9 flag forced low by enable", rd_v, 0);
    wr(0, 1);
    rd(4); chk("R9 no byte after re-enable", rd_v, 0);

    // R11 consuming read collides with a new byte
    push(8'hA1);
    @(negedge clk);
    bus_addr = 12'h004; bus_rd = 1'b1;
    ent_valid = 1'b1; ent_data = 8'hB2;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R11 read returns old byte", bus_rdata, 8'hA1);
    chk("R11 new byte not taken yet", int'(ent_ready), 1);
    @(negedge clk);
    ent_valid = 1'b0;
    chk("R11 new byte taken next edge", int'(ent_ready), 0);
    rd(4); chk("R11 new byte delivered", rd_v, 8'hB2);

    // R2 / R12 undefined offsets
    wr(0, 8'h29); wr(8, 8'h02);
    for (int a = 0; a < 4096; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        wr(a, 8'hFF);
        rd(a);
        chk("R2 undefined reads zero", rd_v, 0);
        chk("R2 undefined err", int'(rd_e), 1);
      end
    end
    @(negedge clk);
    chk("R12 err is one cycle", int'(bus_err), 0);
    rd(0); chk("R2 ctrl untouched", rd_v, 8'h29);
    chk("R12 err low on defined", int'(rd_e), 0);
    rd(8); chk("R2 mode untouched", rd_v, 8'h02);
    rd(4); chk("R2 data untouched", rd_v, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule